// File: doc/BRIEF.md
# Memory-Mapped Network Port

This block sits between a small processor's load/store bus and the local port of one network router. Software sees two 32-bit registers: a mailbox word and a command/status word. To send a message, software stores the outgoing word into the mailbox, then writes the command word with a destination node number and the send bit set. To receive, it polls the status for the received-word flag and then loads the mailbox. Both directions carry one word per message, so blocking and non-blocking send and receive are built in software from polling the status bits.

Toward the router both directions use valid/ready handshakes. An outgoing word is offered with `net_out_valid` and stays on the pins unchanged, together with its destination, until the router raises `net_out_ready` in the same cycle. An incoming word is accepted only in a cycle where both `net_in_valid` and `net_in_ready` are high. `net_in_ready` stays low while an earlier word has not yet been loaded by software, so the router holds its word and nothing is lost. Bus reads return data in the same cycle the read strobe is high. Their side effects, and those of writes, take effect at the next rising clock edge.

Top module: `mmio_net_port`

## Requirements
- R1: After reset, `net_out_valid` is 0, `net_in_ready` is 1, and the status word reads 0.
- R2: The mailbox is at byte address 0x0800_0000 and the command/status word is at 0x0800_0004, decoded on all 32 address bits. Writes to any other address have no effect. Reads of any other address return 0.
- R3: A write to the mailbox stores the outgoing word. A command write with bit 0 set, while no send is pending, offers that word on `net_out_data` with `net_out_dest` equal to bits 15:8 of the command write. `net_out_valid` rises in the cycle after the write.
- R4: Status bit 1 (busy) is 1 from the cycle after an accepted send request until the cycle after the router handshake, and then returns to 0. Status bit 0 always reads 0.
- R5: A send request made while busy is ignored. The word and destination on the pins do not change, and no second word is offered after the pending one completes. A mailbox write while busy does not alter the word being offered.
- R6: While `net_out_valid` is 1 and `net_out_ready` is 0, `net_out_valid`, `net_out_data` and `net_out_dest` stay unchanged.
- R7: A word accepted from the router sets status bit 2 (received-valid), and a mailbox read returns that word.
- R8: A mailbox read while status bit 2 is set clears that bit and returns `net_in_ready` to 1 in the next cycle.
- R9: While status bit 2 is set, `net_in_ready` is 0 and the held word is not replaced. A word offered meanwhile is accepted only after the read, so no word is dropped.
- R10: Bits 15:8 of the status word read back the last destination written. A command write with bit 0 clear changes only that field and starts no send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the bus access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| net_out_valid | output | 1 | Outgoing word offered to the router |
| net_out_ready | input | 1 | Router takes the outgoing word |
| net_out_data | output | 32 | Outgoing word |
| net_out_dest | output | 8 | Destination node of the outgoing word |
| net_in_valid | input | 1 | Router offers an incoming word |
| net_in_ready | output | 1 | Block can take an incoming word |
| net_in_data | input | 32 | Incoming word |

## Verification
The hardest case to reach is back-pressure toward the router: a second incoming word must arrive while the first is still unread, and must then be taken in the cycle right after the mailbox read. The bench keeps the router's valid high with a new word throughout, polls status during the hold, and checks that the second word appears only after the read. On the send side, it sweeps router stall lengths and issues a competing send request and mailbox write during each stall. This shows that the in-flight word and destination stay unchanged and that no stray second send follows.

// File: rtl/nif_pkg.sv
package nif_pkg;
  localparam int WORD_W      = 32;
  localparam int CS_REQ_BIT  = 0;
  localparam int CS_BUSY_BIT = 1;
  localparam int CS_RXV_BIT  = 2;
  localparam int CS_DEST_LSB = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MBOX = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/nif_decode.sv
module nif_decode #(
  parameter int          ADDR_W = 32,
  parameter logic [31:0] BASE   = 32'h0800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              wr_mbox,
  output logic              wr_ctrl,
  output logic              rd_mbox,
  output logic              rd_ctrl
);
  import nif_pkg::*;

  localparam logic [ADDR_W-1:0] MBOX_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(BASE + 32'd4);

  reg_sel_e sel;

  always_comb begin
    if (addr == MBOX_A)      sel = SEL_MBOX;
    else if (addr == CTRL_A) sel = SEL_CTRL;
    else                     sel = SEL_NONE;
  end

  assign wr_mbox = wr && (sel == SEL_MBOX);
  assign wr_ctrl = wr && (sel == SEL_CTRL);
  assign rd_mbox = rd && (sel == SEL_MBOX);
  assign rd_ctrl = rd && (sel == SEL_CTRL);

  // R2: at most one register written per access
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_mbox, wr_ctrl}));
endmodule

// File: rtl/nif_tx_path.sv
module nif_tx_path #(
  parameter int WORD_W = 32,
  parameter int NODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mbox,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              req_bit,
  input  logic [NODE_W-1:0] dest_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [NODE_W-1:0] out_dest,
  output logic              busy,
  output logic [NODE_W-1:0] dest_cfg
);
  logic [WORD_W-1:0] mbox_word;
  logic [WORD_W-1:0] snap_word;
  logic [NODE_W-1:0] snap_dest;
  logic              pending;
  logic              send_req;

  assign send_req = wr_ctrl && req_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbox_word <= '0;
      dest_cfg  <= '0;
    end else begin
      if (wr_mbox) mbox_word <= wr_word;
      if (wr_ctrl) dest_cfg  <= dest_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      snap_word <= '0;
      snap_dest <= '0;
    end else if (pending) begin
      if (out_ready) pending <= 1'b0;
    end else if (send_req) begin
      pending   <= 1'b1;
      snap_word <= mbox_word;
      snap_dest <= dest_in;
    end
  end

  assign out_valid = pending;
  assign out_data  = snap_word;
  assign out_dest  = snap_dest;
  assign busy      = pending;

  // R6: offer held steady under back-pressure
  assert_hold_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dest));
  // R4: busy drops once the router takes the word
  assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !busy);
  // R5: a request while busy leaves the offer untouched
  assert_ignore_busy_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && send_req |=> $stable(out_data) && $stable(out_dest));
endmodule

// File: rtl/nif_rx_path.sv
module nif_rx_path #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              rd_mbox,
  output logic              in_ready,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  logic take;

  assign in_ready = !full;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (take) begin
      full <= 1'b1;
      word <= in_data;
    end else if (rd_mbox && full) begin
      full <= 1'b0;
    end
  end

  // R7: an accepted word is captured and flagged
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> full && (word == $past(in_data)));
  // R9: unread word is never replaced
  assert_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_mbox |=> full && $stable(word));
  // R8: a read of a full mailbox frees it
  assert_read_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full && rd_mbox |=> in_ready);
endmodule

// File: rtl/mmio_net_port.sv
module mmio_net_port #(
  parameter int          NODE_W = 8,
  parameter logic [31:0] BASE   = 32'h0800_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        net_out_valid,
  input  logic        net_out_ready,
  output logic [31:0] net_out_data,
  output logic [NODE_W-1:0] net_out_dest,
  input  logic        net_in_valid,
  output logic        net_in_ready,
  input  logic [31:0] net_in_data
);
  import nif_pkg::*;

  logic wr_mbox, wr_ctrl, rd_mbox, rd_ctrl;
  logic tx_busy, rx_full;
  logic [NODE_W-1:0] dest_cfg;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] status;

  nif_decode #(.ADDR_W(32), .BASE(BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wr_mbox(wr_mbox), .wr_ctrl(wr_ctrl), .rd_mbox(rd_mbox), .rd_ctrl(rd_ctrl)
  );

  nif_tx_path #(.WORD_W(WORD_W), .NODE_W(NODE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_mbox(wr_mbox), .wr_ctrl(wr_ctrl),
    .wr_word(bus_wdata), .req_bit(bus_wdata[CS_REQ_BIT]),
    .dest_in(bus_wdata[CS_DEST_LSB +: NODE_W]), .out_ready(net_out_ready),
    .out_valid(net_out_valid), .out_data(net_out_data), .out_dest(net_out_dest),
    .busy(tx_busy), .dest_cfg(dest_cfg)
  );

  nif_rx_path #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(net_in_valid), .in_data(net_in_data),
    .rd_mbox(rd_mbox), .in_ready(net_in_ready), .full(rx_full), .word(rx_word)
  );

  always_comb begin
    status = '0;
    status[CS_BUSY_BIT] = tx_busy;
    status[CS_RXV_BIT]  = rx_full;
    status[CS_DEST_LSB +: NODE_W] = dest_cfg;
  end

  always_comb begin
    if (rd_mbox)      bus_rdata = rx_word;
    else if (rd_ctrl) bus_rdata = status;
    else              bus_rdata = '0;
  end

  // R2: unmapped reads return zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !rd_mbox && !rd_ctrl |-> bus_rdata == '0);
endmodule

// File: tb/mmio_net_port_bench.sv
`timescale 1ns/100ps
module mmio_net_port_bench;
  localparam logic [31:0] MB = 32'h0800_0000;
  localparam logic [31:0] CS = 32'h0800_0004;

  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, net_in_data = 0;
  logic bus_rd = 0, bus_wr = 0, net_out_ready = 0, net_in_valid = 0;
  logic [31:0] bus_rdata, net_out_data;
  logic [7:0] net_out_dest;
  logic net_out_valid, net_in_ready;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mmio_net_port u_mmio_net_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .net_out_valid(net_out_valid),
    .net_out_ready(net_out_ready), .net_out_data(net_out_data), .net_out_dest(net_out_dest),
    .net_in_valid(net_in_valid), .net_in_ready(net_in_ready), .net_in_data(net_in_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] dest, input logic go);
    return {16'h0, dest, 7'h0, go};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {31'b0, net_out_valid}, 0);
    chk("R1 in_ready", {31'b0, net_in_ready}, 1);
    rd(CS, r); chk("R1 status", r, 0);

    // R10 dest field without send
    wr(CS, cmd(8'h5A, 0));
    rd(CS, r); chk("R10 dest readback", r, 32'h0000_5A00);
    chk("R10 no send", {31'b0, net_out_valid}, 0);

    // R2 unmapped addresses
    wr(MB + 32'h8, cmd(8'h11, 1));
    wr(CS | 32'h0010_0000, cmd(8'h22, 1));
    chk("R2 unmapped write no send", {31'b0, net_out_valid}, 0);
    rd(CS, r); chk("R2 unmapped write no dest change", r, 32'h0000_5A00);
    rd(MB + 32'h8, r); chk("R2 unmapped read zero", r, 0);

    // R3..R6 send sweep over stall lengths and patterns
    for (int dly = 0; dly < 4; dly++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] w;
        logic [7:0]  d;
        w = 32'h1357_9BDF ^ (32'h0101_0101 * (dly * 4 + p + 1));
        d = 8'((p * 37 + dly * 5) ^ 8'hC3);
        wr(MB, w);
        wr(CS, cmd(d, 1));
        chk("R3 valid after request", {31'b0, net_out_valid}, 1);
        chk("R3 data", net_out_data, w);
        chk("R3 dest", {24'b0, net_out_dest}, {24'b0, d});
        rd(CS, r); chk("R4 busy, req bit zero", r & 32'h3, 32'h2);
        wr(MB, ~w);
        wr(CS, cmd(~d, 1));
        chk("R5 data kept", net_out_data, w);
        chk("R5 dest kept", {24'b0, net_out_dest}, {24'b0, d});
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          chk("R6 held valid", {31'b0, net_out_valid}, 1);
          chk("R6 held data", net_out_data, w);
        end
        net_out_ready = 1;
        @(negedge clk);
        net_out_ready = 0;
        chk("R4 valid drops after handshake", {31'b0, net_out_valid}, 0);
        rd(CS, r); chk("R4 busy clear", r & 32'h3, 0);
        repeat (2) @(negedge clk);
        chk("R5 no second send", {31'b0, net_out_valid}, 0);
      end
    end

    // R7..R9 receive with back-pressure
    for (int p = 0; p < 6; p++) begin
      logic [31:0] w1, w2;
      w1 = 32'hA5A5_0000 + 32'(p * 977);
      w2 = ~w1 ^ 32'(p);
      @(negedge clk);
      net_in_valid = 1; net_in_data = w1;
      #1 chk("R7 ready while empty", {31'b0, net_in_ready}, 1);
      @(negedge clk);
      net_in_data = w2;
      chk("R9 not ready while full", {31'b0, net_in_ready}, 0);
      rd(CS, r); chk("R7 rx valid set", r & 32'h4, 32'h4);
      repeat (p) @(negedge clk);
      chk("R9 still not ready", {31'b0, net_in_ready}, 0);
      rd(MB, r); chk("R7 read first word", r, w1);
      chk("R8 ready after read", {31'b0, net_in_ready}, 1);
      @(negedge clk);
      net_in_valid = 0;
      rd(MB, r); chk("R9 second word kept", r, w2);
      rd(CS, r); chk("R8 rx valid clear", r & 32'h4, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule